// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers five hardware interrupt request lines for a small processor core and decides which one the core should service next. One line is a non-maskable emergency input, three are maskable lines that each jump to a fixed vector address, and one is a general-purpose maskable line that has no vector of its own. Each line is qualified by its own trigger rule. Software masks and a global enable then gate the maskable lines, and a fixed priority picks one winner when several lines are pending together.

The core raises a boundary strobe in any cycle where an instruction has just completed. While the strobe is high, the block answers in the same cycle. For a vectored winner it raises a take pulse and puts the 16-bit vector address on the vector bus. For the general-purpose line it drives an active-low acknowledge instead, so that external logic can supply the target. On the clock edge that ends that cycle the block updates its state: the winner's pending record is consumed and, for any maskable winner, the global enable is cleared.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With several lines eligible in the same boundary cycle, the winner is chosen in this fixed order, highest first: emergency line, edge line `irq_edge_i`, level line `irq_lvl_hi_i`, level line `irq_lvl_lo_i`, general line `irq_gen_i`.
- R2: The vector addresses are 0x0024 for the emergency line, 0x003C for `irq_edge_i`, 0x0034 for `irq_lvl_hi_i` and 0x002C for `irq_lvl_lo_i`. Each is eight times the line's fractional index (4.5, 7.5, 6.5, 5.5). `vec_o` is 0 whenever `take_o` is low.
- R3: The emergency line becomes pending only when it is sampled high on `TRAP_HOLD` (default 2) consecutive clock edges, and the first of those samples must follow a low sample. A shorter pulse is dropped. Neither the global enable nor the mask can block the emergency line.
- R4: Accepting the emergency line clears its pending record. A new request on that line is recognised only after the line has first been sampled low again.
- R5: A rising edge on `irq_edge_i` sets a capture flag even while that line is masked or disabled. The flag holds until its interrupt is accepted or reset is applied. Holding the line high does not set the flag again.
- R6: `irq_lvl_hi_i`, `irq_lvl_lo_i` and `irq_gen_i` are not stored: a level that drops before the boundary cycle is lost.
- R7: When the general line wins, `int_ack_n_o` is low in the boundary cycle, and in that same cycle `take_o` is low and `vec_o` is 0.
- R8: The global enable is 0 after reset. `ie_set_i` sets it and `ie_clr_i` clears it. Accepting any maskable line clears it, and accepting the emergency line leaves it unchanged.
- R9: The mask register is written from `mask_wdata_i` when `mask_we_i` is high. Bit 2 masks `irq_edge_i`, bit 1 masks `irq_lvl_hi_i`, bit 0 masks `irq_lvl_lo_i`, and a 1 blocks the line. Reset sets all three bits. The general line has no mask bit.
- R10: `take_o` and a low `int_ack_n_o` appear only in cycles where `boundary_i` is high. Without the strobe, pending requests simply wait.
- R11: Directly after reset no line can be taken, even with all level inputs high and the strobe asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_nmi_i | input | 1 | Non-maskable emergency request |
| irq_edge_i | input | 1 | Rising-edge captured maskable request |
| irq_lvl_hi_i | input | 1 | Level maskable request, higher of the two |
| irq_lvl_lo_i | input | 1 | Level maskable request, lower of the two |
| irq_gen_i | input | 1 | General-purpose level request without vector |
| ie_set_i | input | 1 | Set global enable |
| ie_clr_i | input | 1 | Clear global enable |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | Mask write data, 1 = masked |
| boundary_i | input | 1 | Instruction-boundary strobe |
| take_o | output | 1 | Vectored interrupt taken this cycle |
| vec_o | output | 16 | Vector address for the taken interrupt |
| int_ack_n_o | output | 1 | Active-low acknowledge for the general line |

## Verification
The outputs `take_o`, `vec_o` and `int_ack_n_o` are due in the same cycle as the boundary strobe. The bench therefore raises the strobe just after a falling edge and samples one nanosecond later, before the next rising edge. The effects that pass through registers show up one rising edge later: the consumed pending records, the cleared enable, mask and enable writes, and the edge capture. The emergency line becomes pending `TRAP_HOLD` rising edges after it goes high. Each check is placed after exactly that many falling-edge steps, so the bench always reads a settled value.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC = 5;
  localparam int unsigned VEC_W = 16;
  // source slots, highest index wins
  localparam int unsigned IDX_NMI = 4;
  localparam int unsigned IDX_EDGE = 3;
  localparam int unsigned IDX_LHI = 2;
  localparam int unsigned IDX_LLO = 1;
  localparam int unsigned IDX_GEN = 0;
  // fractional index doubled: 4.5, 7.5, 6.5, 5.5
  localparam int unsigned DBL_NMI = 9;
  localparam int unsigned DBL_EDGE = 15;
  localparam int unsigned DBL_LHI = 13;
  localparam int unsigned DBL_LLO = 11;

  // vector = fractional index * 8 = doubled index * 4
  function automatic logic [VEC_W-1:0] vec_of(input logic [NSRC-1:0] g);
    logic [VEC_W-1:0] v;
    v = '0;
    if (g[IDX_NMI]) v = VEC_W'(DBL_NMI * 4);
    else if (g[IDX_EDGE]) v = VEC_W'(DBL_EDGE * 4);
    else if (g[IDX_LHI]) v = VEC_W'(DBL_LHI * 4);
    else if (g[IDX_LLO]) v = VEC_W'(DBL_LLO * 4);
    return v;
  endfunction
endpackage

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic take_i,
  output logic pend_o
);
  localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

  logic armed_q;
  logic [CW-1:0] cnt_q;
  logic pend_q;
  logic qual_done;

  assign qual_done = line_i && armed_q && (cnt_q == CW'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (take_i) pend_q <= 1'b0;
      if (!line_i) begin
        armed_q <= 1'b1;
        cnt_q <= '0;
      end else if (armed_q) begin
        if (qual_done) begin
          pend_q <= 1'b1;
          armed_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pend_o = pend_q;

  AST_NMI_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(line_i)); // R3
  AST_NMI_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && line_i && !armed_q) |=> !pend_q); // R4
endmodule

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic rise;

  assign rise = pin_i && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (rise) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R5
  AST_EDGE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(pin_i)); // R5
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] above;

  always_comb begin
    above[N] = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      grant_o[i] = req_i[i] && !above[i+1];
      above[i] = above[i+1] || req_i[i];
    end
  end

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant_o)); // R1
    AST_GRANT_REQ: assert ((grant_o & ~req_i) == '0); // R1
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned TRAP_HOLD = 2,
  parameter int unsigned MASK_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_nmi_i,
  input  logic irq_edge_i,
  input  logic irq_lvl_hi_i,
  input  logic irq_lvl_lo_i,
  input  logic irq_gen_i,
  input  logic ie_set_i,
  input  logic ie_clr_i,
  input  logic mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  input  logic boundary_i,
  output logic take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic int_ack_n_o
);
  logic ie_q;
  logic [MASK_W-1:0] mask_q;
  logic nmi_pend;
  logic edge_flag;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic nmi_taken;
  logic edge_taken;
  logic maskable_taken;

  irq_nmi_qual #(.HOLD(TRAP_HOLD)) u_nmi (
    .clk(clk), .rst_n(rst_n), .line_i(irq_nmi_i),
    .take_i(nmi_taken), .pend_o(nmi_pend));

  irq_edge_cap u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(irq_edge_i),
    .clr_i(edge_taken), .flag_o(edge_flag));

  assign req[IDX_NMI] = nmi_pend;
  assign req[IDX_EDGE] = ie_q && !mask_q[2] && edge_flag;
  assign req[IDX_LHI] = ie_q && !mask_q[1] && irq_lvl_hi_i;
  assign req[IDX_LLO] = ie_q && !mask_q[0] && irq_lvl_lo_i;
  assign req[IDX_GEN] = ie_q && irq_gen_i;

  irq_prio_sel #(.N(NSRC)) u_sel (.req_i(req), .grant_o(grant));

  assign nmi_taken = boundary_i && grant[IDX_NMI];
  assign edge_taken = boundary_i && grant[IDX_EDGE];
  assign maskable_taken = boundary_i && (|grant[IDX_EDGE:IDX_GEN]);

  assign take_o = boundary_i && (|grant[IDX_NMI:IDX_LLO]);
  assign vec_o = take_o ? vec_of(grant) : '0;
  assign int_ack_n_o = !(boundary_i && grant[IDX_GEN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
      mask_q <= '1;
    end else begin
      if (maskable_taken || ie_clr_i) ie_q <= 1'b0;
      else if (ie_set_i) ie_q <= 1'b1;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && nmi_pend) |-> (take_o && vec_o == 16'h0024)); // R1
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_o && !int_ack_n_o)); // R7
  AST_IE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    maskable_taken |=> !ie_q); // R8
  AST_NMI_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_taken && ie_q && !ie_clr_i) |=> ie_q); // R8
  AST_NEED_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |-> (!take_o && int_ack_n_o)); // R10
endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi = 0, edg = 0, lhi = 0, llo = 0, gen = 0;
  logic ie_set = 0, ie_clr = 0, mwe = 0, bnd = 0;
  logic [2:0] mdat = 3'b000;
  logic take;
  logic [15:0] vec;
  logic ack_n;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_nmi_i(nmi), .irq_edge_i(edg),
    .irq_lvl_hi_i(lhi), .irq_lvl_lo_i(llo), .irq_gen_i(gen),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .mask_we_i(mwe),
    .mask_wdata_i(mdat), .boundary_i(bnd), .take_o(take),
    .vec_o(vec), .int_ack_n_o(ack_n));

  // {mask, lhi, llo, gen, take, ack_n, vector}
  localparam logic [23:0] TBL [8] = '{
    {3'b000, 3'b111, 2'b11, 16'h0034},
    {3'b010, 3'b111, 2'b11, 16'h002C},
    {3'b011, 3'b111, 2'b00, 16'h0000},
    {3'b111, 3'b110, 2'b01, 16'h0000},
    {3'b000, 3'b011, 2'b11, 16'h002C},
    {3'b001, 3'b010, 2'b01, 16'h0000},
    {3'b101, 3'b100, 2'b11, 16'h0034},
    {3'b000, 3'b001, 2'b00, 16'h0000}};

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // strobe boundary for one cycle, check {take, ack_n, vec}
  task automatic probe(input string tag, input logic et, input logic ea, input logic [15:0] ev);
    bnd = 1'b1;
    #1;
    check(tag, {14'd0, take, ack_n, vec}, {14'd0, et, ea, ev});
    step();
    bnd = 1'b0;
  endtask

  task automatic enable(input logic on);
    if (on) ie_set = 1'b1; else ie_clr = 1'b1;
    step();
    ie_set = 1'b0;
    ie_clr = 1'b0;
  endtask

  task automatic wmask(input logic [2:0] m);
    mwe = 1'b1;
    mdat = m;
    step();
    mwe = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11: nothing taken right after reset
    lhi = 1; llo = 1; gen = 1;
    probe("R11 reset state", 1'b0, 1'b1, 16'h0000);
    gen = 0;
    // R9 reset mask blocks levels even once enabled; R8 enable then general line
    enable(1'b1);
    probe("R9 reset mask", 1'b0, 1'b1, 16'h0000);
    lhi = 0; llo = 0; gen = 1;
    probe("R7 general ack", 1'b0, 1'b0, 16'h0000);
    gen = 0;

    // table: R1 R2 R7 R9
    for (int k = 0; k < 8; k++) begin
      wmask(TBL[k][23:21]);
      enable(1'b1);
      lhi = TBL[k][20]; llo = TBL[k][19]; gen = TBL[k][18];
      probe($sformatf("R1/R2/R7/R9 table %0d", k), TBL[k][17], TBL[k][16], TBL[k][15:0]);
      lhi = 0; llo = 0; gen = 0;
      enable(1'b0);
    end

    // R3: short emergency pulse dropped, with enable off
    wmask(3'b111);
    nmi = 1; step(); nmi = 0; step();
    probe("R3 short pulse", 1'b0, 1'b1, 16'h0000);
    nmi = 1; step(); step();
    #1 check("R10 no strobe", {31'd0, take}, 32'd0);
    probe("R3 qualified, R2 vector", 1'b1, 1'b1, 16'h0024);
    step();
    probe("R4 no rearm while high", 1'b0, 1'b1, 16'h0000);
    nmi = 0; step(); nmi = 1; step(); step();
    probe("R4 rearm after low", 1'b1, 1'b1, 16'h0024);
    nmi = 0;

    // R1 emergency over edge line; R8 enable kept after emergency
    wmask(3'b000);
    enable(1'b1);
    edg = 1; step(); edg = 0; step();
    nmi = 1; step(); step();
    probe("R1 emergency over edge", 1'b1, 1'b1, 16'h0024);
    nmi = 0;
    probe("R8 enable kept, R5 edge vector", 1'b1, 1'b1, 16'h003C);
    enable(1'b1);
    probe("R5 flag consumed", 1'b0, 1'b1, 16'h0000);

    // R5 capture while masked and disabled
    wmask(3'b111);
    enable(1'b0);
    edg = 1; step(); edg = 0; step();
    wmask(3'b000);
    enable(1'b1);
    probe("R5 captured while masked", 1'b1, 1'b1, 16'h003C);
    enable(1'b1);
    edg = 1; step();
    probe("R5 edge accepted", 1'b1, 1'b1, 16'h003C);
    enable(1'b1);
    probe("R5 held level no recapture", 1'b0, 1'b1, 16'h0000);
    edg = 0;

    // R6 level dropped before boundary
    lhi = 1; step(); lhi = 0;
    probe("R6 level lost", 1'b0, 1'b1, 16'h0000);

    // R8 clear command and clear on accept
    enable(1'b0);
    llo = 1;
    probe("R8 disabled", 1'b0, 1'b1, 16'h0000);
    enable(1'b1);
    probe("R8 enabled lo line", 1'b1, 1'b1, 16'h002C);
    probe("R8 cleared by accept", 1'b0, 1'b1, 16'h0000);
    llo = 0;

    finish_run();
  end
endmodule